// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block maps instruction fetch addresses from virtual to physical space through a small translation cache. The cache is organised as sets and ways. Software fills it through a register port, one tag word and one mapping word per entry. A fetch request is captured in a register, looked up combinationally in the next cycle, and its result is registered. The result is a physical address, a cache-inhibit flag and at most one of two exception strobes: a table miss or an execute-permission fault. Each entry keeps a small usage counter that ages on every hit in its set, so that refill software can choose a victim.

When translation is switched off, or the block is built without a translation table, addresses pass straight through. The cache-inhibit flag then follows the top address bit. A second lookup port answers debug queries against the same table. It never ages entries and never raises strobes. A read-back port returns any stored word, and a constant output word reports the table geometry.

Top module: `itlb_xlate`

## Requirements
- R1: With `xlat_en` low, or with `MMU_PRESENT` = 0, a fetch returns `out_pa` equal to the fetch address and `out_ci` equal to its top bit, with neither strobe. Every result is presented with `out_valid` two rising edges after the request is sampled.
- R2: The set is selected by fetch address bits [PAGE_BITS +: SETS_LOG2]. A way matches only when bit 0 (valid) of its tag word is set and tag-word bits [AW-1 : PAGE_BITS+SETS_LOG2] equal the same bits of the fetch address.
- R3: On a match, `out_pa` is mapping-word bits [AW-1:PAGE_BITS] joined with fetch address bits [PAGE_BITS-1:0], and `out_ci` is mapping-word bit 0.
- R4: On a match, `out_fault` is raised when the mode's execute bit in the mapping word is clear. Supervisor mode (`fetch_super` = 1) uses bit 1 and user mode uses bit 2.
- R5: On no match with translation on, `out_miss` is raised, `out_va` carries the fetch address, `out_pa` is 0, `out_ci` is 0, and no stored word changes.
- R6: On a match, every other way of the selected set whose usage field (tag-word bits [6 +: SETS_LOG2]) is nonzero counts down by one. The matching way's field is set to all ones. A fault does not prevent this update.
- R7: When several ways of a set match, the lowest-numbered way supplies the result.
- R8: The debug port returns `dbg_pa` one edge after its inputs. The value is the address itself when `dbg_xlat_en` is low, the translated address on a permitted match, and 0 on a miss or a permission failure. A debug query changes no usage field and raises no strobe.
- R9: A table write (`wr_sel` 0 = tag word, 1 = mapping word) is seen by a fetch sampled on the next edge. A write to a tag word wins over a usage update to the same entry in the same cycle.
- R10: `cfg_word` bits [1:0] hold WAYS-1, bits [4:2] hold SETS_LOG2, and all other bits are 0.
- R11: After reset, `out_valid` is low and every stored word reads back as 0.
- R12: `out_miss` and `out_fault` are never high together and are high only with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch lookup request |
| fetch_va | input | AW | Fetch virtual address |
| fetch_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| xlat_en | input | 1 | Translation enable for the fetch |
| out_valid | output | 1 | Result valid |
| out_pa | output | AW | Physical address |
| out_ci | output | 1 | Cache-inhibit flag |
| out_miss | output | 1 | Table-miss strobe |
| out_fault | output | 1 | Execute-permission fault strobe |
| out_va | output | AW | Virtual address of the reported fetch |
| wr_en | input | 1 | Table write enable |
| wr_sel | input | 1 | 0 = tag word, 1 = mapping word |
| wr_set | input | SETS_LOG2 | Write set index |
| wr_way | input | WAY_W | Write way index |
| wr_data | input | AW | Word to write |
| rb_sel | input | 1 | Read-back word select, encoded as for wr_sel |
| rb_set | input | SETS_LOG2 | Read-back set index |
| rb_way | input | WAY_W | Read-back way index |
| rb_data | output | AW | Read-back word, one edge later |
| dbg_va | input | AW | Debug query address |
| dbg_super | input | 1 | Debug query mode |
| dbg_xlat_en | input | 1 | Debug query translation enable |
| dbg_pa | output | AW | Debug query result |
| cfg_word | output | 8 | Geometry report |

## Verification
The bound checker watches every cycle for exclusive strobes qualified by `out_valid`, for the two-edge result latency, for the pass-through path on both ports, and for a zero address on every miss. Translation values, permission decisions, the lowest-way choice, usage ageing and the timing of writes depend on table contents. Only the scoreboard scenarios can show these, by comparing against a reference table kept in the bench and by reading stored words back after each sequence.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  // Tag word layout
  localparam int MW_VLD_BIT = 0;
  localparam int MW_USE_LSB = 6;

  // Mapping word layout
  localparam int XW_CI_BIT = 0;
  localparam int XW_SX_BIT = 1;
  localparam int XW_UX_BIT = 2;

  typedef enum logic {
    TBL_MATCH = 1'b0,
    TBL_XLATE = 1'b1
  } tbl_sel_e;

  function automatic logic exec_allowed(input logic sx, input logic ux, input logic sup);
    return sup ? sx : ux;
  endfunction

endpackage

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SETS_LOG2 = 2,
  parameter int WAYS      = 2,
  parameter int WAY_W     = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        wr_sel,
  input  logic [SETS_LOG2-1:0]        wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [AW-1:0]               wr_data,
  input  logic                        upd_en,
  input  logic [SETS_LOG2-1:0]        upd_set,
  input  logic [WAY_W-1:0]            upd_way,
  input  logic [SETS_LOG2-1:0]        rd_set_a,
  output logic [WAYS-1:0][AW-1:0]     match_a,
  output logic [WAYS-1:0][AW-1:0]     xlate_a,
  input  logic [SETS_LOG2-1:0]        rd_set_b,
  output logic [WAYS-1:0][AW-1:0]     match_b,
  output logic [WAYS-1:0][AW-1:0]     xlate_b,
  input  logic                        rb_sel,
  input  logic [SETS_LOG2-1:0]        rb_set,
  input  logic [WAY_W-1:0]            rb_way,
  output logic [AW-1:0]               rb_data
);

  localparam int SETS = 1 << SETS_LOG2;

  logic [AW-1:0] mw_q [SETS][WAYS];
  logic [AW-1:0] xw_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          mw_q[s][w] <= '0;
          xw_q[s][w] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (wr_en && wr_set == SETS_LOG2'(s) && wr_way == WAY_W'(w) &&
              tbl_sel_e'(wr_sel) == TBL_XLATE) begin
            xw_q[s][w] <= wr_data;
          end
          if (wr_en && wr_set == SETS_LOG2'(s) && wr_way == WAY_W'(w) &&
              tbl_sel_e'(wr_sel) == TBL_MATCH) begin
            mw_q[s][w] <= wr_data;
          end else if (upd_en && upd_set == SETS_LOG2'(s)) begin
            if (upd_way == WAY_W'(w)) begin
              mw_q[s][w][MW_USE_LSB +: SETS_LOG2] <= '1;
            end else if (mw_q[s][w][MW_USE_LSB +: SETS_LOG2] != '0) begin
              mw_q[s][w][MW_USE_LSB +: SETS_LOG2] <=
                mw_q[s][w][MW_USE_LSB +: SETS_LOG2] - 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match_a[w] = mw_q[rd_set_a][w];
      xlate_a[w] = xw_q[rd_set_a][w];
      match_b[w] = mw_q[rd_set_b][w];
      xlate_b[w] = xw_q[rd_set_b][w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_data <= '0;
    end else if (tbl_sel_e'(rb_sel) == TBL_MATCH) begin
      rb_data <= mw_q[rb_set][rb_way];
    end else begin
      rb_data <= xw_q[rb_set][rb_way];
    end
  end

endmodule

// File: rtl/itlb_hit.sv
module itlb_hit
  import itlb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int WAYS    = 2,
  parameter int WAY_W   = 1,
  parameter int TAG_LSB = 15
) (
  input  logic [AW-1:0]           va,
  input  logic [WAYS-1:0][AW-1:0] set_match,
  output logic                    hit,
  output logic [WAY_W-1:0]        hit_way
);

  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = set_match[w][MW_VLD_BIT] &&
                        (set_match[w][AW-1:TAG_LSB] == va[AW-1:TAG_LSB]);
  end

  // lowest numbered way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |way_hit;

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 13,
  parameter int SETS_LOG2   = 2,
  parameter int WAYS        = 2,
  parameter bit MMU_PRESENT = 1'b1,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_req,
  input  logic [AW-1:0]        fetch_va,
  input  logic                 fetch_super,
  input  logic                 xlat_en,
  output logic                 out_valid,
  output logic [AW-1:0]        out_pa,
  output logic                 out_ci,
  output logic                 out_miss,
  output logic                 out_fault,
  output logic [AW-1:0]        out_va,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [SETS_LOG2-1:0] wr_set,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [AW-1:0]        wr_data,
  input  logic                 rb_sel,
  input  logic [SETS_LOG2-1:0] rb_set,
  input  logic [WAY_W-1:0]     rb_way,
  output logic [AW-1:0]        rb_data,
  input  logic [AW-1:0]        dbg_va,
  input  logic                 dbg_super,
  input  logic                 dbg_xlat_en,
  output logic [AW-1:0]        dbg_pa,
  output logic [7:0]           cfg_word
);

  localparam int TAG_LSB = PAGE_BITS + SETS_LOG2;

  // request stage
  logic          s_req;
  logic [AW-1:0] s_va;
  logic          s_sup;
  logic          s_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_req <= 1'b0;
      s_va  <= '0;
      s_sup <= 1'b0;
      s_en  <= 1'b0;
    end else begin
      s_req <= fetch_req;
      s_va  <= fetch_va;
      s_sup <= fetch_super;
      s_en  <= xlat_en;
    end
  end

  logic [SETS_LOG2-1:0]    f_set, d_set;
  logic [WAYS-1:0][AW-1:0] f_match, f_xlate, d_match, d_xlate;
  logic                    f_hit, d_hit;
  logic [WAY_W-1:0]        f_way, d_way;
  logic                    upd_en;

  assign f_set = s_va[PAGE_BITS +: SETS_LOG2];
  assign d_set = dbg_va[PAGE_BITS +: SETS_LOG2];

  itlb_store #(
    .AW(AW), .SETS_LOG2(SETS_LOG2), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_set(wr_set), .wr_way(wr_way), .wr_data(wr_data),
    .upd_en(upd_en), .upd_set(f_set), .upd_way(f_way),
    .rd_set_a(f_set), .match_a(f_match), .xlate_a(f_xlate),
    .rd_set_b(d_set), .match_b(d_match), .xlate_b(d_xlate),
    .rb_sel(rb_sel), .rb_set(rb_set), .rb_way(rb_way), .rb_data(rb_data)
  );

  itlb_hit #(
    .AW(AW), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_LSB(TAG_LSB)
  ) u_fetch_hit (
    .va(s_va), .set_match(f_match), .hit(f_hit), .hit_way(f_way)
  );

  itlb_hit #(
    .AW(AW), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_LSB(TAG_LSB)
  ) u_dbg_hit (
    .va(dbg_va), .set_match(d_match), .hit(d_hit), .hit_way(d_way)
  );

  // fetch path
  logic          f_active;
  logic [AW-1:0] f_xw, f_pa;
  logic          f_ok;

  assign f_active = s_en && MMU_PRESENT;
  assign f_xw     = f_xlate[f_way];
  assign f_pa     = {f_xw[AW-1:PAGE_BITS], s_va[PAGE_BITS-1:0]};
  assign f_ok     = exec_allowed(f_xw[XW_SX_BIT], f_xw[XW_UX_BIT], s_sup);
  assign upd_en   = s_req && f_active && f_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_ci    <= 1'b0;
      out_miss  <= 1'b0;
      out_fault <= 1'b0;
      out_va    <= '0;
    end else begin
      out_valid <= s_req;
      out_va    <= s_va;
      if (!f_active) begin
        out_pa    <= s_va;
        out_ci    <= s_va[AW-1];
        out_miss  <= 1'b0;
        out_fault <= 1'b0;
      end else if (f_hit) begin
        out_pa    <= f_pa;
        out_ci    <= f_xw[XW_CI_BIT];
        out_miss  <= 1'b0;
        out_fault <= s_req && !f_ok;
      end else begin
        out_pa    <= '0;
        out_ci    <= 1'b0;
        out_miss  <= s_req;
        out_fault <= 1'b0;
      end
    end
  end

  // debug path
  logic [AW-1:0] d_xw;
  logic          d_ok;

  assign d_xw = d_xlate[d_way];
  assign d_ok = exec_allowed(d_xw[XW_SX_BIT], d_xw[XW_UX_BIT], dbg_super);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_pa <= '0;
    end else if (!(dbg_xlat_en && MMU_PRESENT)) begin
      dbg_pa <= dbg_va;
    end else if (d_hit && d_ok) begin
      dbg_pa <= {d_xw[AW-1:PAGE_BITS], dbg_va[PAGE_BITS-1:0]};
    end else begin
      dbg_pa <= '0;
    end
  end

  assign cfg_word = {3'b000, 3'(SETS_LOG2), 2'(WAYS - 1)};

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
  parameter int AW          = 32,
  parameter bit MMU_PRESENT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_va,
  input logic          xlat_en,
  input logic          out_valid,
  input logic [AW-1:0] out_pa,
  input logic          out_ci,
  input logic          out_miss,
  input logic          out_fault,
  input logic [AW-1:0] dbg_va,
  input logic          dbg_xlat_en,
  input logic [AW-1:0] dbg_pa
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_miss, out_fault}));

  // R12
  strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_miss || out_fault) |-> out_valid);

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(fetch_req, 2) && ($past(!xlat_en, 2) || !MMU_PRESENT))
    |-> (out_valid && out_pa == $past(fetch_va, 2) && out_ci == $past(fetch_va[AW-1], 2)
         && !out_miss && !out_fault));

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(fetch_req, 2)));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_pa == '0 && !out_ci));

  // R8
  dbg_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && ($past(!dbg_xlat_en) || !MMU_PRESENT)) |-> (dbg_pa == $past(dbg_va)));

endmodule

bind itlb_xlate itlb_xlate_chk #(.AW(AW), .MMU_PRESENT(MMU_PRESENT)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_va(fetch_va), .xlat_en(xlat_en),
  .out_valid(out_valid), .out_pa(out_pa), .out_ci(out_ci), .out_miss(out_miss),
  .out_fault(out_fault), .dbg_va(dbg_va), .dbg_xlat_en(dbg_xlat_en), .dbg_pa(dbg_pa)
);

// File: tb/itlb_xlate_bench.sv
`timescale 1ns/1ps
module itlb_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_va = '0;
  logic        fetch_super = 1'b0;
  logic        xlat_en = 1'b0;
  logic        out_valid, out_ci, out_miss, out_fault;
  logic [31:0] out_pa, out_va;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [1:0]  wr_set = '0;
  logic        wr_way = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rb_sel = 1'b0;
  logic [1:0]  rb_set = '0;
  logic        rb_way = 1'b0;
  logic [31:0] rb_data;
  logic [31:0] dbg_va = '0;
  logic        dbg_super = 1'b0;
  logic        dbg_xlat_en = 1'b0;
  logic [31:0] dbg_pa;
  logic [7:0]  cfg_word;

  always #2.5 clk = ~clk;

  itlb_xlate u_itlb_xlate (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_va(fetch_va), .fetch_super(fetch_super), .xlat_en(xlat_en),
    .out_valid(out_valid), .out_pa(out_pa), .out_ci(out_ci), .out_miss(out_miss),
    .out_fault(out_fault), .out_va(out_va),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_set(wr_set), .wr_way(wr_way), .wr_data(wr_data),
    .rb_sel(rb_sel), .rb_set(rb_set), .rb_way(rb_way), .rb_data(rb_data),
    .dbg_va(dbg_va), .dbg_super(dbg_super), .dbg_xlat_en(dbg_xlat_en), .dbg_pa(dbg_pa),
    .cfg_word(cfg_word)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] pa;
    logic        ci;
    logic        miss;
    logic        fault;
    logic [31:0] va;
    logic [31:0] dbg;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference table, index = set*2 + way
  logic [31:0] m_mw [8];
  logic [31:0] m_xw [8];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mdl(logic [31:0] va, logic sup, logic en, string tag, bit apply);
    exp_t e;
    int set;
    int hw;
    bit hit;
    logic [31:0] xw;
    e.tag = tag; e.va = va; e.pa = '0; e.ci = 1'b0; e.miss = 1'b0; e.fault = 1'b0; e.dbg = '0;
    if (!en) begin
      e.pa = va; e.ci = va[31]; e.dbg = va;
      return e;
    end
    set = int'(va[14:13]);
    hit = 0; hw = 0;
    for (int w = 0; w < 2; w++) begin
      if (!hit && m_mw[set*2+w][0] && m_mw[set*2+w][31:15] == va[31:15]) begin
        hit = 1; hw = w;
      end
    end
    if (!hit) begin
      e.miss = 1'b1;
      return e;
    end
    xw = m_xw[set*2+hw];
    e.pa = {xw[31:13], va[12:0]};
    e.ci = xw[0];
    e.fault = sup ? !xw[1] : !xw[2];
    e.dbg = e.fault ? 32'h0 : e.pa;
    if (apply) begin
      for (int w = 0; w < 2; w++) begin
        if (w == hw) m_mw[set*2+w][7:6] = 2'b11;
        else if (m_mw[set*2+w][7:6] != 2'b00) m_mw[set*2+w][7:6] = m_mw[set*2+w][7:6] - 2'b01;
      end
    end
    return e;
  endfunction

  task automatic fetch(logic [31:0] va, logic sup, logic en, string tag);
    q.push_back(mdl(va, sup, en, tag, 1));
    fetch_req = 1'b1; fetch_va = va; fetch_super = sup; xlat_en = en;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic twrite(logic sel, int set, int way, logic [31:0] data);
    if (sel) m_xw[set*2+way] = data; else m_mw[set*2+way] = data;
    wr_en = 1'b1; wr_sel = sel; wr_set = 2'(set); wr_way = 1'(way); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tread(logic sel, int set, int way, string tag);
    rb_sel = sel; rb_set = 2'(set); rb_way = 1'(way);
    @(negedge clk);
    chk(tag, "readback", rb_data, sel ? m_xw[set*2+way] : m_mw[set*2+way]);
  endtask

  task automatic dbgq(logic [31:0] va, logic sup, logic en, string tag);
    exp_t e;
    e = mdl(va, sup, en, tag, 0);
    dbg_va = va; dbg_super = sup; dbg_xlat_en = en;
    @(negedge clk);
    chk(tag, "dbg_pa", dbg_pa, e.dbg);
    chk("R8", "no strobe during debug", {31'b0, out_valid}, 32'h0);
    dbg_xlat_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected result act valid=1 exp valid=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "pa", out_pa, e.pa);
        chk(e.tag, "ci", {31'b0, out_ci}, {31'b0, e.ci});
        chk(e.tag, "miss", {31'b0, out_miss}, {31'b0, e.miss});
        chk(e.tag, "fault", {31'b0, out_fault}, {31'b0, e.fault});
        if (e.miss) chk(e.tag, "miss va", out_va, e.va);
      end
    end
  end

  initial begin
    #250000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_mw[i] = '0; m_xw[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11", "out_valid", {31'b0, out_valid}, 32'h0);
    tread(1'b0, 1, 0, "R11");
    tread(1'b1, 3, 1, "R11");
    // R10 geometry word
    chk("R10", "cfg_word", {24'b0, cfg_word}, 32'h0000_0009);

    // R1 pass-through, both halves of the space
    fetch(32'h7FFF_FFFC, 1'b1, 1'b0, "R1");
    fetch(32'h8000_0010, 1'b0, 1'b0, "R1");
    // R5 empty table misses
    fetch(32'h0040_2ABC, 1'b1, 1'b1, "R5");
    repeat (3) @(negedge clk);

    // fill set 1
    twrite(1'b0, 1, 0, 32'h0040_0001);
    twrite(1'b1, 1, 0, 32'h9ABC_E003);
    twrite(1'b0, 1, 1, 32'h0080_0001);
    twrite(1'b1, 1, 1, 32'h1111_0006);

    // R3 supervisor hit with ci, R4 user fault, R3 way 1
    fetch(32'h0040_2ABC, 1'b1, 1'b1, "R3");
    fetch(32'h0040_2ABC, 1'b0, 1'b1, "R4");
    fetch(32'h0080_3FF0, 1'b0, 1'b1, "R3");
    // R2 tag mismatch and wrong set
    fetch(32'h00C0_2000, 1'b1, 1'b1, "R2");
    fetch(32'h0040_0000, 1'b1, 1'b1, "R2");
    repeat (3) @(negedge clk);
    // R6 usage fields after hits, R5 misses left them alone
    tread(1'b0, 1, 0, "R6");
    tread(1'b0, 1, 1, "R6");
    chk("R6", "way0 usage", m_mw[2], 32'h0040_0081);
    chk("R6", "way1 usage", m_mw[3], 32'h0080_00C1);

    // R6 back-to-back ageing down to zero
    fetch(32'h0080_2004, 1'b1, 1'b1, "R6");
    fetch(32'h0080_2008, 1'b1, 1'b1, "R6");
    fetch(32'h0080_200C, 1'b1, 1'b1, "R6");
    repeat (3) @(negedge clk);
    tread(1'b0, 1, 0, "R6");
    tread(1'b0, 1, 1, "R6");

    // R7 duplicate tags in set 2
    twrite(1'b0, 2, 0, 32'h0000_0001);
    twrite(1'b1, 2, 0, 32'h2000_0006);
    twrite(1'b0, 2, 1, 32'h0000_0001);
    twrite(1'b1, 2, 1, 32'h3000_0006);
    fetch(32'h0000_4010, 1'b0, 1'b1, "R7");
    // R9 invalidate way 0 then fetch on the very next cycle
    twrite(1'b0, 2, 0, 32'h0000_0000);
    fetch(32'h0000_4010, 1'b0, 1'b1, "R9");
    repeat (3) @(negedge clk);

    // R8 debug queries
    dbgq(32'h0040_2ABC, 1'b1, 1'b1, "R8");
    dbgq(32'h0040_2ABC, 1'b0, 1'b1, "R8");
    dbgq(32'h00C0_2000, 1'b1, 1'b1, "R8");
    dbgq(32'h8123_4567, 1'b0, 1'b0, "R8");
    tread(1'b0, 1, 0, "R8");
    tread(1'b0, 1, 1, "R8");

    repeat (3) @(negedge clk);
    chk("R1", "results outstanding", q.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule